// File: doc/BRIEF.md
# STS-3 Transmit Overhead Inserter

This block builds a complete outgoing STS-3 frame, one byte per clock. Upstream logic hands it payload bytes in frame order, either from one concatenated STS-3c source or from three byte-interleaved STS-1 sources, and marks the first byte of each frame. The block keeps its own row and column count. It fills the section and line overhead columns with framing bytes, configured bytes and the two parity bytes. It can insert line RDI, line REI and line AIS, invert a parity byte on demand for testing, and apply the frame-synchronous scrambler.

A timing state machine has two states. In `FR_WAIT` the block emits no valid bytes. The transition *first start* moves it to `FR_RUN` when `i_sof` is high. In `FR_RUN` the transition *byte advance* steps the column on every cycle and wraps the row at the end of a row. The transition *realign* returns the count to row 0, column 0 whenever `i_sof` is high.

Each of the two parity error injectors is a three-state machine. In `INJ_IDLE`, the transition *request* goes to `INJ_ARMED`. In `INJ_ARMED`, *window open* either corrupts a one-byte window at once (going back to idle, or staying armed if a new request came in) or enters `INJ_ACTIVE` for a longer window. In `INJ_ACTIVE`, *window close* returns to `INJ_IDLE`, or to `INJ_ARMED` if a new request arrived on the closing byte.

Top module: `tx_toh_inserter`

## Requirements
- R1: `o_valid` stays low until the first `i_sof`. Every byte leaves exactly one cycle after it enters. The byte that enters with `i_sof` leaves as row 0, column 0 with `o_sof` high. Positions then run over columns 0..269 and rows 0..8.
- R2: Row 0, columns 0..8, carry 0xF6, 0xF6, 0xF6, 0x28, 0x28, 0x28, `i_cfg_j0`, 0x02, 0x03, in that order. These bytes are never scrambled.
- R3: Columns 9..269 of every row, and columns 0..8 of row 3, carry the input byte. In concatenated mode (`i_sts3c`=1) that byte is `i_spe_c`. Otherwise it is byte k of `i_spe_ch` (bits 8k+7..8k), where k is the column mod 3.
- R4: Four overhead positions take their value from a configuration input:
  - row 1, column 3 takes `i_cfg_e1`;
  - row 1, column 6 takes `i_cfg_f1`;
  - row 4, column 3 takes `i_cfg_k1`;
  - row 8, column 0 takes `i_cfg_s1`.

  Every other overhead position not named in R2, R5 to R8 is 0x00.
- R5: Row 1, column 0 carries the even parity per bit position, taken over every output byte of the previous frame after scrambling. It is 0x00 in the first frame.
- R6: Row 4, column k (k = 0..2) carries the even parity over the previous frame's rows 3..8 bytes whose column mod 3 equals k. The parity is taken before scrambling. These bytes are 0x00 in the first frame.
- R7: Row 4, column 6 carries `i_cfg_k2`. When `i_rdi` is high, bits 2..0 of that byte are replaced by 110.
- R8: Row 8, column 5 carries `i_rei_cnt` clamped to at most 24.
- R9: While `i_ais` is high, every byte of rows 3..8 is 0xFF before scrambling. This overrides R3, R4, R6, R7 and R8.
- R10: With `i_scr_en` high, every byte except row 0, columns 0..8, is XORed with the sequence of the generator 1 + x^6 + x^7. The generator is restarted to all ones at row 0, column 9, so the first mask byte is 0xFE. With `i_scr_en` low, bytes leave unchanged.
- R11: A pulse on `i_err_b1` causes the next section parity byte emitted strictly after the pulse to be sent with every bit inverted. Only that one frame is affected.
- R12: A pulse on `i_err_b2` causes all three line parity bytes of the next row 4 window emitted strictly after the pulse to be inverted. Only that one frame is affected. The window is used up even if AIS masks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low reset |
| i_sof | input | 1 | First byte of a frame |
| i_sts3c | input | 1 | 1: concatenated payload, 0: three STS-1 payloads |
| i_spe_c | input | 8 | Concatenated payload byte |
| i_spe_ch | input | NSTS*8 | Per-STS-1 payload bytes, channel k in bits 8k+7..8k |
| i_cfg_j0 | input | 8 | Trace byte value |
| i_cfg_e1 | input | 8 | Section orderwire value |
| i_cfg_f1 | input | 8 | Section user byte value |
| i_cfg_k1 | input | 8 | Protection byte 1 value |
| i_cfg_k2 | input | 8 | Protection byte 2 value |
| i_cfg_s1 | input | 8 | Sync status value |
| i_rei_cnt | input | REI_W | Remote error count |
| i_rdi | input | 1 | Send line RDI |
| i_ais | input | 1 | Send line AIS |
| i_scr_en | input | 1 | Scrambler enable |
| i_err_b1 | input | 1 | Corrupt next section parity byte |
| i_err_b2 | input | 1 | Corrupt next line parity bytes |
| o_valid | output | 1 | Output byte valid |
| o_sof | output | 1 | Output byte is row 0, column 0 |
| o_row | output | RW | Row of output byte |
| o_col | output | CW | Column of output byte |
| o_byte | output | 8 | Output byte |

## Verification
Two functions can claim the same byte. A forced line-parity error can fall into a frame that is sending line AIS, and both then act on the row 4 parity bytes. The bench provokes this by pulsing `i_err_b2` during an AIS frame. It then checks that the parity bytes leave as 0xFF, that the request is used up, and that the next frame's line parity is correct and not inverted. The same frame also asserts RDI, so that RDI and AIS meet on the K2 byte.

// File: rtl/tx_toh_pkg.sv
package tx_toh_pkg;

    typedef enum logic {
        FR_WAIT = 1'b0,
        FR_RUN  = 1'b1
    } frm_state_t;

    typedef enum logic [1:0] {
        INJ_IDLE   = 2'd0,
        INJ_ARMED  = 2'd1,
        INJ_ACTIVE = 2'd2
    } inj_state_t;

    localparam logic [7:0] FRAME_BYTE_1 = 8'hF6;
    localparam logic [7:0] FRAME_BYTE_2 = 8'h28;
    localparam logic [6:0] SCR_SEED     = 7'h7F;

    // Eight bits of generator output, MSB first
    function automatic logic [7:0] scr_mask(input logic [6:0] st);
        logic [6:0] s;
        logic [7:0] m;
        s = st;
        m = '0;
        for (int i = 0; i < 8; i++) begin
            m = {m[6:0], s[6]};
            s = {s[5:0], s[6] ^ s[5]};
        end
        return m;
    endfunction

    // Generator state after eight steps
    function automatic logic [6:0] scr_adv(input logic [6:0] st);
        logic [6:0] s;
        s = st;
        for (int i = 0; i < 8; i++) begin
            s = {s[5:0], s[6] ^ s[5]};
        end
        return s;
    endfunction

endpackage

// File: rtl/toh_framer.sv
module toh_framer
    import tx_toh_pkg::*;
#(
    parameter int ROWS = 9,
    parameter int COLS = 270,
    parameter int NSTS = 3,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS),
    localparam int SW = $clog2(NSTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_sof,
    output logic          o_run,
    output logic          o_first,
    output logic [RW-1:0] o_row,
    output logic [CW-1:0] o_col,
    output logic [SW-1:0] o_sidx
);

    frm_state_t st_q, st_d;

    logic [RW-1:0] row_q, row_c, row_n;
    logic [CW-1:0] col_q, col_c, col_n;
    logic [SW-1:0] sidx_q, sidx_c, sidx_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_WAIT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_WAIT: if (i_sof) st_d = FR_RUN;
            FR_RUN:  st_d = FR_RUN;
        endcase
    end

    assign o_run  = (st_q == FR_RUN) || i_sof;
    assign row_c  = i_sof ? '0 : row_q;
    assign col_c  = i_sof ? '0 : col_q;
    assign sidx_c = i_sof ? '0 : sidx_q;

    always_comb begin
        row_n  = row_c;
        col_n  = col_c + CW'(1);
        sidx_n = (sidx_c == SW'(NSTS - 1)) ? '0 : sidx_c + SW'(1);
        if (col_c == CW'(COLS - 1)) begin
            col_n  = '0;
            sidx_n = '0;
            row_n  = (row_c == RW'(ROWS - 1)) ? '0 : row_c + RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            sidx_q <= '0;
        end else if (o_run) begin
            row_q  <= row_n;
            col_q  <= col_n;
            sidx_q <= sidx_n;
        end
    end

    assign o_row   = row_c;
    assign o_col   = col_c;
    assign o_sidx  = sidx_c;
    assign o_first = o_run && (row_c == '0) && (col_c == '0);

    // R1
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_RUN) |-> (col_q < CW'(COLS) && row_q < RW'(ROWS) && sidx_q < SW'(NSTS)));

endmodule

// File: rtl/toh_scrambler.sv
module toh_scrambler
    import tx_toh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i_adv,
    input  logic       i_restart,
    output logic [7:0] o_mask
);

    logic [6:0] lfsr_q, lfsr_d;

    always_comb begin
        lfsr_d = lfsr_q;
        if (i_restart)  lfsr_d = SCR_SEED;
        else if (i_adv) lfsr_d = scr_adv(lfsr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SCR_SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign o_mask = scr_mask(lfsr_q);

    // R10
    scr_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i_restart |=> (o_mask == 8'hFE));

endmodule

// File: rtl/toh_parity.sv
module toh_parity #(
    parameter int NSTS = 3,
    localparam int SW = $clog2(NSTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            i_en,
    input  logic            i_first,
    input  logic            i_line,
    input  logic [SW-1:0]   i_sidx,
    input  logic [7:0]      i_tx,
    input  logic [7:0]      i_pre,
    output logic [7:0]      o_b1,
    output logic [NSTS*8-1:0] o_b2
);

    logic [7:0] b1_acc, b1_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b1_acc  <= '0;
            b1_hold <= '0;
        end else if (i_en) begin
            if (i_first) begin
                b1_hold <= b1_acc;
                b1_acc  <= i_tx;
            end else begin
                b1_acc  <= b1_acc ^ i_tx;
            end
        end
    end

    assign o_b1 = b1_hold;

    for (genvar k = 0; k < NSTS; k++) begin : g_line
        logic [7:0] acc, hold;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc  <= '0;
                hold <= '0;
            end else if (i_en) begin
                if (i_first) begin
                    hold <= acc;
                    acc  <= '0;
                end else if (i_line && i_sidx == SW'(k)) begin
                    acc  <= acc ^ i_pre;
                end
            end
        end
        assign o_b2[k*8 +: 8] = hold;
    end

    // R5
    b1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_en || !i_first) |=> $stable(o_b1));

endmodule

// File: rtl/toh_err_inject.sv
module toh_err_inject
    import tx_toh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic i_req,
    input  logic i_win_start,
    input  logic i_win_end,
    input  logic i_in_win,
    output logic o_flip
);

    inj_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= INJ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            INJ_IDLE: begin
                if (i_req) st_d = INJ_ARMED;
            end
            INJ_ARMED: begin
                if (i_win_start) begin
                    if (i_win_end) st_d = i_req ? INJ_ARMED : INJ_IDLE;
                    else           st_d = INJ_ACTIVE;
                end
            end
            INJ_ACTIVE: begin
                if (i_win_end) st_d = i_req ? INJ_ARMED : INJ_IDLE;
            end
            default: st_d = INJ_IDLE;
        endcase
    end

    always_comb begin
        o_flip = 1'b0;
        unique case (st_q)
            INJ_ARMED:  o_flip = i_win_start;
            INJ_ACTIVE: o_flip = i_in_win;
            default:    o_flip = 1'b0;
        endcase
    end

    // R11
    inj_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == INJ_IDLE && i_req) |=> (st_q == INJ_ARMED));

    // R12
    inj_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_flip |-> i_in_win);

endmodule

// File: rtl/tx_toh_inserter.sv
module tx_toh_inserter
    import tx_toh_pkg::*;
#(
    parameter int ROWS    = 9,
    parameter int COLS    = 270,
    parameter int OH_COLS = 9,
    parameter int NSTS    = 3,
    parameter int REI_W   = 8,
    parameter int REI_MAX = 24,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS),
    localparam int SW = $clog2(NSTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               i_sof,
    input  logic               i_sts3c,
    input  logic [7:0]         i_spe_c,
    input  logic [NSTS*8-1:0]  i_spe_ch,
    input  logic [7:0]         i_cfg_j0,
    input  logic [7:0]         i_cfg_e1,
    input  logic [7:0]         i_cfg_f1,
    input  logic [7:0]         i_cfg_k1,
    input  logic [7:0]         i_cfg_k2,
    input  logic [7:0]         i_cfg_s1,
    input  logic [REI_W-1:0]   i_rei_cnt,
    input  logic               i_rdi,
    input  logic               i_ais,
    input  logic               i_scr_en,
    input  logic               i_err_b1,
    input  logic               i_err_b2,
    output logic               o_valid,
    output logic               o_sof,
    output logic [RW-1:0]      o_row,
    output logic [CW-1:0]      o_col,
    output logic [7:0]         o_byte
);

    localparam int ROW_PTR  = 3;
    localparam int ROW_LINE = 4;
    localparam int ROW_LAST = 8;

    logic          run, first;
    logic [RW-1:0] row;
    logic [CW-1:0] col;
    logic [SW-1:0] sidx;
    logic [7:0]    mask, b1_prev, payload, pre, tx, m1_val;
    logic [NSTS*8-1:0] b2_prev;
    logic          flip_b1, flip_b2;
    logic          oh_col, in_soh0, scr_restart;
    logic          b1_win, b2_start, b2_end, b2_win;
    int            r_i, c_i;

    toh_framer #(.ROWS(ROWS), .COLS(COLS), .NSTS(NSTS)) u_framer (
        .clk(clk), .rst_n(rst_n), .i_sof(i_sof),
        .o_run(run), .o_first(first), .o_row(row), .o_col(col), .o_sidx(sidx)
    );

    assign oh_col      = col < CW'(OH_COLS);
    assign in_soh0     = (row == '0) && oh_col;
    assign scr_restart = run && (row == '0) && (col == CW'(OH_COLS - 1));

    toh_scrambler u_scr (
        .clk(clk), .rst_n(rst_n), .i_adv(run && !in_soh0),
        .i_restart(scr_restart), .o_mask(mask)
    );

    assign b1_win   = run && (row == RW'(1)) && (col == '0);
    assign b2_start = run && (row == RW'(ROW_LINE)) && (col == '0);
    assign b2_end   = run && (row == RW'(ROW_LINE)) && (col == CW'(NSTS - 1));
    assign b2_win   = run && (row == RW'(ROW_LINE)) && (col < CW'(NSTS));

    toh_err_inject u_inj_b1 (
        .clk(clk), .rst_n(rst_n), .i_req(i_err_b1),
        .i_win_start(b1_win), .i_win_end(b1_win), .i_in_win(b1_win),
        .o_flip(flip_b1)
    );

    toh_err_inject u_inj_b2 (
        .clk(clk), .rst_n(rst_n), .i_req(i_err_b2),
        .i_win_start(b2_start), .i_win_end(b2_end), .i_in_win(b2_win),
        .o_flip(flip_b2)
    );

    toh_parity #(.NSTS(NSTS)) u_par (
        .clk(clk), .rst_n(rst_n), .i_en(run), .i_first(first),
        .i_line(row >= RW'(ROW_PTR)), .i_sidx(sidx),
        .i_tx(tx), .i_pre(pre), .o_b1(b1_prev), .o_b2(b2_prev)
    );

    assign payload = i_sts3c ? i_spe_c : i_spe_ch[int'(sidx)*8 +: 8];
    assign m1_val  = (i_rei_cnt > REI_W'(REI_MAX)) ? 8'(REI_MAX) : 8'(i_rei_cnt);

    // Byte selection before scrambling
    always_comb begin
        r_i = int'(row);
        c_i = int'(col);
        pre = 8'h00;
        if (!oh_col || r_i == ROW_PTR) begin
            pre = payload;
        end else begin
            case (r_i)
                0: begin
                    if (c_i < NSTS)              pre = FRAME_BYTE_1;
                    else if (c_i < 2 * NSTS)     pre = FRAME_BYTE_2;
                    else if (c_i == 2 * NSTS)    pre = i_cfg_j0;
                    else                         pre = 8'(c_i - 2 * NSTS + 1);
                end
                1: begin
                    case (c_i)
                        0:       pre = b1_prev ^ {8{flip_b1}};
                        3:       pre = i_cfg_e1;
                        6:       pre = i_cfg_f1;
                        default: pre = 8'h00;
                    endcase
                end
                ROW_LINE: begin
                    if (c_i < NSTS)  pre = b2_prev[c_i*8 +: 8] ^ {8{flip_b2}};
                    else if (c_i == 3) pre = i_cfg_k1;
                    else if (c_i == 6) pre = i_rdi ? {i_cfg_k2[7:3], 3'b110} : i_cfg_k2;
                    else             pre = 8'h00;
                end
                ROW_LAST: begin
                    case (c_i)
                        0:       pre = i_cfg_s1;
                        5:       pre = m1_val;
                        default: pre = 8'h00;
                    endcase
                end
                default: pre = 8'h00;
            endcase
        end
        if (i_ais && r_i >= ROW_PTR) pre = 8'hFF;
    end

    assign tx = (i_scr_en && !in_soh0) ? (pre ^ mask) : pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_sof   <= 1'b0;
            o_row   <= '0;
            o_col   <= '0;
            o_byte  <= '0;
        end else begin
            o_valid <= run;
            o_sof   <= first;
            o_row   <= run ? row : '0;
            o_col   <= run ? col : '0;
            o_byte  <= run ? tx : 8'h00;
        end
    end

    // R1
    sof_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_sof |-> (o_valid && o_row == '0 && o_col == '0));

    // R2
    a1_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_row == '0 && o_col < CW'(NSTS)) |-> (o_byte == FRAME_BYTE_1));

endmodule

// File: tb/sim_tx_toh_inserter.sv
`timescale 1ns/1ps
module sim_tx_toh_inserter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_sof = 0, i_sts3c = 0, i_rdi = 0, i_ais = 0, i_scr_en = 0;
    logic        i_err_b1 = 0, i_err_b2 = 0;
    logic [7:0]  i_spe_c = 0, i_cfg_j0 = 0, i_cfg_e1 = 0, i_cfg_f1 = 0;
    logic [7:0]  i_cfg_k1 = 0, i_cfg_k2 = 0, i_cfg_s1 = 0, i_rei_cnt = 0;
    logic [23:0] i_spe_ch = 0;
    logic        o_valid, o_sof;
    logic [3:0]  o_row;
    logic [8:0]  o_col;
    logic [7:0]  o_byte;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model state
    bit         m_run = 0, exp_valid = 0, exp_sof = 0;
    int         m_r = 0, m_c = 0, exp_r = 0, exp_c = 0;
    logic [7:0] exp_byte = 0, m_b1acc = 0, m_b1prev = 0;
    logic [7:0] m_b2acc [3];
    logic [7:0] m_b2prev [3];
    logic [6:0] m_lfsr = 7'h7F;
    bit         m_pend1 = 0, m_pend2 = 0, m_act2 = 0;
    string      exp_req = "";

    // staged frame configuration
    bit n_mode, n_scr, n_ais, n_rdi;
    logic [7:0] n_rei;

    tx_toh_inserter u0 (
        .clk(clk), .rst_n(rst_n), .i_sof(i_sof), .i_sts3c(i_sts3c),
        .i_spe_c(i_spe_c), .i_spe_ch(i_spe_ch),
        .i_cfg_j0(i_cfg_j0), .i_cfg_e1(i_cfg_e1), .i_cfg_f1(i_cfg_f1),
        .i_cfg_k1(i_cfg_k1), .i_cfg_k2(i_cfg_k2), .i_cfg_s1(i_cfg_s1),
        .i_rei_cnt(i_rei_cnt), .i_rdi(i_rdi), .i_ais(i_ais), .i_scr_en(i_scr_en),
        .i_err_b1(i_err_b1), .i_err_b2(i_err_b2),
        .o_valid(o_valid), .o_sof(o_sof), .o_row(o_row), .o_col(o_col), .o_byte(o_byte)
    );

    always #10 clk = ~clk;

    function automatic string req_of(int r, int c, bit ais, bit scr);
        string s;
        if (ais && r >= 3)              s = "R9";
        else if (r == 0 && c < 9)       s = "R2";
        else if (r == 1 && c == 0)      s = "R5 R11";
        else if (r == 4 && c < 3)       s = "R6 R12";
        else if (r == 4 && c == 6)      s = "R4 R7";
        else if (r == 8 && c == 5)      s = "R8";
        else if (c >= 9 || r == 3)      s = "R3";
        else                            s = "R4";
        if (scr && !(r == 0 && c < 9)) s = {s, " R10"};
        return s;
    endfunction

    task automatic check_out();
        n_chk++;
        if (o_valid !== exp_valid ||
            (exp_valid && (o_sof !== exp_sof || int'(o_row) != exp_r || int'(o_col) != exp_c))) begin
            n_fail++;
            $display("FAIL R1 position: got v%0d s%0d row %0d col %0d expected v%0d s%0d row %0d col %0d",
                     o_valid, o_sof, o_row, o_col, exp_valid, exp_sof, exp_r, exp_c);
        end
        if (exp_valid) begin
            n_chk++;
            if (o_byte !== exp_byte) begin
                n_fail++;
                $display("FAIL %s at row %0d col %0d: got %02h expected %02h",
                         exp_req, exp_r, exp_c, o_byte, exp_byte);
            end
        end
    endtask

    task automatic model_byte();
        logic [7:0] pre, tx, m;
        bit f1;
        if (!m_run) begin
            exp_valid = 0;
            return;
        end
        f1 = 0;
        if (m_r == 4 && m_c == 0) begin
            m_act2  = m_pend2;
            m_pend2 = 0;
        end
        if (m_c >= 9 || m_r == 3) begin
            pre = i_sts3c ? i_spe_c : i_spe_ch[(m_c % 3)*8 +: 8];
        end else begin
            pre = 8'h00;
            case (m_r)
                0: pre = (m_c < 3) ? 8'hF6 : (m_c < 6) ? 8'h28 : (m_c == 6) ? i_cfg_j0 :
                         (m_c == 7) ? 8'h02 : 8'h03;
                1: begin
                    if (m_c == 0) begin
                        f1 = m_pend1;
                        m_pend1 = 0;
                        pre = m_b1prev ^ (f1 ? 8'hFF : 8'h00);
                    end
                    else if (m_c == 3) pre = i_cfg_e1;
                    else if (m_c == 6) pre = i_cfg_f1;
                end
                4: begin
                    if (m_c < 3)       pre = m_b2prev[m_c] ^ (m_act2 ? 8'hFF : 8'h00);
                    else if (m_c == 3) pre = i_cfg_k1;
                    else if (m_c == 6) pre = i_rdi ? {i_cfg_k2[7:3], 3'b110} : i_cfg_k2;
                end
                8: begin
                    if (m_c == 0)      pre = i_cfg_s1;
                    else if (m_c == 5) pre = (i_rei_cnt > 8'd24) ? 8'd24 : i_rei_cnt;
                end
                default: pre = 8'h00;
            endcase
        end
        if (i_ais && m_r >= 3) pre = 8'hFF;
        tx = pre;
        if (!(m_r == 0 && m_c < 9)) begin
            if (m_r == 0 && m_c == 9) m_lfsr = 7'h7F;
            m = 0;
            for (int i = 0; i < 8; i++) begin
                m = {m[6:0], m_lfsr[6]};
                m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
            end
            if (i_scr_en) tx = pre ^ m;
        end
        if (m_r == 0 && m_c == 0) begin
            m_b1prev = m_b1acc;
            m_b1acc  = 0;
            for (int k = 0; k < 3; k++) begin
                m_b2prev[k] = m_b2acc[k];
                m_b2acc[k]  = 0;
            end
        end
        m_b1acc = m_b1acc ^ tx;
        if (m_r >= 3) m_b2acc[m_c % 3] = m_b2acc[m_c % 3] ^ pre;
        if (i_err_b1) m_pend1 = 1;
        if (i_err_b2) m_pend2 = 1;
        if (m_r == 4 && m_c == 2) m_act2 = 0;
        exp_valid = 1;
        exp_sof   = (m_r == 0 && m_c == 0);
        exp_r     = m_r;
        exp_c     = m_c;
        exp_byte  = tx;
        exp_req   = req_of(m_r, m_c, i_ais, i_scr_en);
        m_c++;
        if (m_c == 270) begin
            m_c = 0;
            m_r = (m_r == 8) ? 0 : m_r + 1;
        end
    endtask

    task automatic step(input bit s, input bit q1, input bit q2);
        @(negedge clk);
        check_out();
        i_sof    = s;
        i_spe_c  = 8'($urandom);
        i_spe_ch = 24'($urandom);
        i_err_b1 = q1;
        i_err_b2 = q2;
        if (s) begin
            i_sts3c   = n_mode;
            i_scr_en  = n_scr;
            i_ais     = n_ais;
            i_rdi     = n_rdi;
            i_rei_cnt = n_rei;
            i_cfg_j0  = 8'($urandom);
            i_cfg_e1  = 8'($urandom);
            i_cfg_f1  = 8'($urandom);
            i_cfg_k1  = 8'($urandom);
            i_cfg_k2  = 8'($urandom);
            i_cfg_s1  = 8'($urandom);
            m_run = 1;
            m_r   = 0;
            m_c   = 0;
        end
        model_byte();
    endtask

    task automatic run_frame(input bit md, input bit sc, input bit ai, input bit rd,
                             input logic [7:0] rei, input int e1_at, input int e2_at);
        n_mode = md; n_scr = sc; n_ais = ai; n_rdi = rd; n_rei = rei;
        for (int i = 0; i < 2430; i++) begin
            step(i == 0, i == e1_at, i == e2_at);
        end
    endtask

    function automatic int rand_payload_idx();
        return ($urandom % 9) * 270 + 9 + ($urandom % 261);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3; k++) begin
            m_b2acc[k] = 0;
            m_b2prev[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: nothing valid before the first frame start
        for (int i = 0; i < 4; i++) step(0, 0, 0);
        // R5 R6: first frame parity bytes are zero; clean reference frame
        run_frame(1, 0, 0, 0, 8'd5, -1, -1);
        // R11 R10 R8: B1 corruption under scrambling, REI at the limit
        run_frame(0, 1, 0, 0, 8'd24, 1000, -1);
        // R12 R7 R8: both requests in one cycle, REI above limit
        run_frame(1, 1, 0, 1, 8'd25, 1500, 1500);
        // R9 R12 R7: B2 request swallowed by AIS, RDI and AIS on K2
        run_frame(0, 0, 1, 1, 8'd255, -1, 500);
        // R6: line parity after an AIS frame
        run_frame(0, 1, 0, 0, 8'd0, -1, -1);
        for (int f = 0; f < 5; f++) begin
            run_frame($urandom % 2, $urandom % 2, ($urandom % 4) == 0, $urandom % 2,
                      8'($urandom % 40),
                      ($urandom % 2) ? rand_payload_idx() : -1,
                      ($urandom % 2) ? rand_payload_idx() : -1);
        end
        step(0, 0, 0);
        step(0, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule